// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This controller watches the instruction sitting in the decode/register-read stage of a five-stage in-order integer pipeline (fetch, decode/register-read, execute, memory, write-back) together with the three older instructions held in the buffers after decode, execute and memory. From these it chooses where each ALU operand comes from, whether the front of the pipeline must hold, and whether buffers must be turned into NOPs. It also sequences entry into an interrupt. All outputs are combinational in the current inputs and a small interrupt state register. They are meant to drive the buffer enables and operand multiplexers of the datapath. The datapath itself is not part of this block.

Two build-time choices select the variants. `BR_PREDICT` = 0 resolves branches by stalling fetch behind a branch. `BR_PREDICT` = 1 keeps fetching sequentially and flushes on a taken branch. `IRQ_FLUSH` = 0 drains in-flight work before entering an interrupt. `IRQ_FLUSH` = 1 discards that work at once.

A NOP is a buffer entry whose valid flag is clear. It writes neither a register nor memory. A held buffer keeps its previous contents. All pins are plain level controls and there is no valid/ready handshake: the pipeline is fully synchronous and advances every cycle unless a hold is raised.

Top module: `hazard_ctrl`

## Requirements
- R1: Each operand select is 0 for the register file, 1 for the decode-output buffer (the instruction now in execute), 2 for the execute-output buffer and 3 for the memory-output buffer. A buffer matches when its valid and write flags are set and its destination equals the operand's source register.
- R2: When several buffers match the same source, the youngest wins, in the order decode-output buffer, then execute-output buffer, then memory-output buffer.
- R3: A source register number of 0 always selects 0. A buffer whose write flag is clear never matches.
- R4: A load in the decode-output buffer whose destination equals a source of a valid decode instruction raises `hold_pc`, `hold_fbuf` and `bubble_dbuf` together for that cycle. Once the load has moved to the execute-output buffer, the operand selects 2 and nothing is held. A load-use stall takes precedence over a branch stall in decode.
- R5: A taken branch resolution (`br_resolved` and `br_taken`) raises `flush_fbuf` and `bubble_dbuf` and clears both holds. This takes precedence over a load-use stall in the same cycle.
- R6: With `BR_PREDICT`=0, a valid branch in decode raises `hold_pc` and `flush_fbuf`, so one NOP follows the branch and the next fetch is repeated.
- R7: With `BR_PREDICT`=1, a branch in decode raises no control. With either setting, a not-taken resolution raises none.
- R8: With `IRQ_FLUSH`=0, from the cycle a request is seen until interrupt entry, `bubble_dbuf`, `hold_pc` and `hold_fbuf` are high. `irq_enter` pulses for one cycle once the three buffer valids are all low, and the unit then returns to normal. The request may drop after the first cycle.
- R9: A taken branch resolved during a drain raises the R5 flush controls for that cycle, and the drain then continues.
- R10: With `IRQ_FLUSH`=1, a request raises `flush_fbuf`, `bubble_dbuf`, `flush_xbuf` and `irq_enter` in the same cycle, with no hold.
- R11: After reset, with idle inputs, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| src_a | input | REG_W | First source register of decode instruction |
| src_b | input | REG_W | Second source register of decode instruction |
| dbuf_valid | input | 1 | Decode-output buffer valid |
| dbuf_wr | input | 1 | Decode-output buffer writes a register |
| dbuf_load | input | 1 | Decode-output buffer is a load |
| dbuf_rd | input | REG_W | Decode-output buffer destination |
| xbuf_valid | input | 1 | Execute-output buffer valid |
| xbuf_wr | input | 1 | Execute-output buffer writes a register |
| xbuf_rd | input | REG_W | Execute-output buffer destination |
| mbuf_valid | input | 1 | Memory-output buffer valid |
| mbuf_wr | input | 1 | Memory-output buffer writes a register |
| mbuf_rd | input | REG_W | Memory-output buffer destination |
| br_resolved | input | 1 | Branch in execute resolves this cycle |
| br_taken | input | 1 | Resolved branch is taken |
| irq_req | input | 1 | Interrupt request |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| hold_pc | output | 1 | PC keeps its value |
| hold_fbuf | output | 1 | Fetch-output buffer keeps its value |
| bubble_dbuf | output | 1 | Decode-output buffer loads a NOP |
| flush_fbuf | output | 1 | Fetch-output buffer loads a NOP |
| flush_xbuf | output | 1 | Execute-output buffer loads a NOP |
| irq_enter | output | 1 | Interrupt entry |

## Verification
The assertions check four rules on every cycle: a taken resolution always yields the flush pattern with no hold, a fetch hold never appears without the PC hold and a decode bubble, a zero source never forwards, and interrupt entry only pulses with the pipeline empty. Only the bench's scenarios can show the rest. These are the select codes and their priority under mixed matches, the exact one-cycle length of a load-use stall as the load moves on, the differences between the branch variants and between the interrupt variants, and the cycle-by-cycle progress of a drain, including one that a taken branch interrupts.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NOLD  = 3;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF   = 2'd0,
    FWD_DBUF = 2'd1,
    FWD_XBUF = 2'd2,
    FWD_MBUF = 2'd3
  } fwd_src_e;

  typedef enum logic {
    IRQ_IDLE  = 1'b0,
    IRQ_DRAIN = 1'b1
  } irq_state_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]            src,
  input  logic [NOLD-1:0]             valid,
  input  logic [NOLD-1:0]             wr,
  input  logic [NOLD-1:0][REG_W-1:0]  rd,
  output logic [SEL_W-1:0]            sel
);
  // index 0 is the youngest older stage; scanning oldest first lets the
  // youngest match overwrite the rest
  always_comb begin
    sel = SEL_W'(FWD_RF);
    for (int i = NOLD - 1; i >= 0; i--) begin
      if (valid[i] && wr[i] && (rd[i] == src) && (src != '0))
        sel = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic             dec_valid,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             ld_valid,
  input  logic             ld_wr,
  input  logic             ld_is_load,
  input  logic [REG_W-1:0] ld_rd,
  output logic             stall
);
  logic producer;
  logic hit_a, hit_b;

  assign producer = ld_valid && ld_wr && ld_is_load && (ld_rd != '0);
  assign hit_a    = (src_a == ld_rd);
  assign hit_b    = (src_b == ld_rd);
  assign stall    = dec_valid && producer && (hit_a || hit_b);
endmodule

// File: rtl/hz_irq_seq.sv
module hz_irq_seq
  import hz_pkg::*;
#(
  parameter bit FLUSH_MODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic [NOLD-1:0] inflight,
  output logic            drain_on,
  output logic            irq_enter,
  output logic            irq_kill
);
  generate
    if (FLUSH_MODE) begin : g_flush
      assign drain_on  = 1'b0;
      assign irq_kill  = irq_req;
      assign irq_enter = irq_req;
    end else begin : g_drain
      irq_state_e state_q, state_d;
      logic       empty;

      assign empty = (inflight == '0);

      always_comb begin
        state_d = state_q;
        case (state_q)
          IRQ_IDLE:  if (irq_req) state_d = IRQ_DRAIN;
          IRQ_DRAIN: if (empty)   state_d = IRQ_IDLE;
          default:                state_d = IRQ_IDLE;
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
      end

      assign drain_on  = (state_q == IRQ_DRAIN) || irq_req;
      assign irq_enter = (state_q == IRQ_DRAIN) && empty;
      assign irq_kill  = 1'b0;

      // R8: entry only with every older buffer empty
      a_r8_enter_empty: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |-> (inflight == '0));
      // R8: entry is a single-cycle pulse
      a_r8_enter_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> !irq_enter);
    end
  endgenerate
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter bit BR_PREDICT = 1'b0,
  parameter bit IRQ_FLUSH  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             dec_is_branch,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             dbuf_valid,
  input  logic             dbuf_wr,
  input  logic             dbuf_load,
  input  logic [REG_W-1:0] dbuf_rd,
  input  logic             xbuf_valid,
  input  logic             xbuf_wr,
  input  logic [REG_W-1:0] xbuf_rd,
  input  logic             mbuf_valid,
  input  logic             mbuf_wr,
  input  logic [REG_W-1:0] mbuf_rd,
  input  logic             br_resolved,
  input  logic             br_taken,
  input  logic             irq_req,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             hold_pc,
  output logic             hold_fbuf,
  output logic             bubble_dbuf,
  output logic             flush_fbuf,
  output logic             flush_xbuf,
  output logic             irq_enter
);
  localparam int NOPER = 2;

  logic [NOLD-1:0]            old_valid, old_wr;
  logic [NOLD-1:0][REG_W-1:0] old_rd;
  logic [NOPER-1:0][REG_W-1:0] srcs;
  logic [NOPER-1:0][SEL_W-1:0] sels;

  assign old_valid = {mbuf_valid, xbuf_valid, dbuf_valid};
  assign old_wr    = {mbuf_wr,    xbuf_wr,    dbuf_wr};
  assign old_rd    = {mbuf_rd,    xbuf_rd,    dbuf_rd};
  assign srcs      = {src_b, src_a};

  generate
    for (genvar k = 0; k < NOPER; k++) begin : g_oper
      hz_fwd_sel #(.REG_W(REG_W)) u_sel (
        .src   (srcs[k]),
        .valid (old_valid),
        .wr    (old_wr),
        .rd    (old_rd),
        .sel   (sels[k])
      );
    end
  endgenerate

  assign fwd_a = sels[0];
  assign fwd_b = sels[1];

  logic lu_stall;
  hz_load_use #(.REG_W(REG_W)) u_lu (
    .dec_valid  (dec_valid),
    .src_a      (src_a),
    .src_b      (src_b),
    .ld_valid   (dbuf_valid),
    .ld_wr      (dbuf_wr),
    .ld_is_load (dbuf_load),
    .ld_rd      (dbuf_rd),
    .stall      (lu_stall)
  );

  logic drain_on, irq_kill;
  hz_irq_seq #(.FLUSH_MODE(IRQ_FLUSH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .inflight  (old_valid),
    .drain_on  (drain_on),
    .irq_enter (irq_enter),
    .irq_kill  (irq_kill)
  );

  logic br_stall;
  generate
    if (BR_PREDICT) begin : g_pnt
      assign br_stall = 1'b0;
    end else begin : g_stall
      assign br_stall = dec_valid && dec_is_branch;
    end
  endgenerate

  logic take;
  assign take = br_resolved && br_taken;

  // priority: interrupt kill > taken flush > drain > load-use > branch stall
  always_comb begin
    hold_pc     = 1'b0;
    hold_fbuf   = 1'b0;
    bubble_dbuf = 1'b0;
    flush_fbuf  = 1'b0;
    flush_xbuf  = 1'b0;
    if (irq_kill) begin
      flush_fbuf  = 1'b1;
      bubble_dbuf = 1'b1;
      flush_xbuf  = 1'b1;
    end else if (take) begin
      flush_fbuf  = 1'b1;
      bubble_dbuf = 1'b1;
    end else if (drain_on || lu_stall) begin
      hold_pc     = 1'b1;
      hold_fbuf   = 1'b1;
      bubble_dbuf = 1'b1;
    end else if (br_stall) begin
      hold_pc     = 1'b1;
      flush_fbuf  = 1'b1;
    end
  end

  // R5: taken resolution always flushes front and never holds
  a_r5_taken_flush: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (flush_fbuf && bubble_dbuf && !hold_pc && !hold_fbuf));
  // R4: a held fetch buffer comes with a held PC and a decode bubble
  a_r4_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fbuf |-> (hold_pc && bubble_dbuf));
  // R3: register 0 never forwards
  a_r3_zero_src_a: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != FWD_RF) |-> (src_a != '0));
  a_r3_zero_src_b: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b != FWD_RF) |-> (src_b != '0));
endmodule

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       dec_valid, dec_is_branch;
  logic [4:0] src_a, src_b, dbuf_rd, xbuf_rd, mbuf_rd;
  logic       dbuf_valid, dbuf_wr, dbuf_load;
  logic       xbuf_valid, xbuf_wr, mbuf_valid, mbuf_wr;
  logic       br_resolved, br_taken, irq_req;

  logic [1:0] m_fa, m_fb, a_fa, a_fb;
  logic m_hp, m_hf, m_bd, m_ff, m_fx, m_ie;
  logic a_hp, a_hf, a_bd, a_ff, a_fx, a_ie;

  hazard_ctrl #(.REG_W(5), .BR_PREDICT(1'b0), .IRQ_FLUSH(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
    .src_a(src_a), .src_b(src_b), .dbuf_valid(dbuf_valid), .dbuf_wr(dbuf_wr),
    .dbuf_load(dbuf_load), .dbuf_rd(dbuf_rd), .xbuf_valid(xbuf_valid),
    .xbuf_wr(xbuf_wr), .xbuf_rd(xbuf_rd), .mbuf_valid(mbuf_valid),
    .mbuf_wr(mbuf_wr), .mbuf_rd(mbuf_rd), .br_resolved(br_resolved),
    .br_taken(br_taken), .irq_req(irq_req), .fwd_a(m_fa), .fwd_b(m_fb),
    .hold_pc(m_hp), .hold_fbuf(m_hf), .bubble_dbuf(m_bd), .flush_fbuf(m_ff),
    .flush_xbuf(m_fx), .irq_enter(m_ie));

  hazard_ctrl #(.REG_W(5), .BR_PREDICT(1'b1), .IRQ_FLUSH(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
    .src_a(src_a), .src_b(src_b), .dbuf_valid(dbuf_valid), .dbuf_wr(dbuf_wr),
    .dbuf_load(dbuf_load), .dbuf_rd(dbuf_rd), .xbuf_valid(xbuf_valid),
    .xbuf_wr(xbuf_wr), .xbuf_rd(xbuf_rd), .mbuf_valid(mbuf_valid),
    .mbuf_wr(mbuf_wr), .mbuf_rd(mbuf_rd), .br_resolved(br_resolved),
    .br_taken(br_taken), .irq_req(irq_req), .fwd_a(a_fa), .fwd_b(a_fb),
    .hold_pc(a_hp), .hold_fbuf(a_hf), .bubble_dbuf(a_bd), .flush_fbuf(a_ff),
    .flush_xbuf(a_fx), .irq_enter(a_ie));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [9:0] q_main[$];
  logic [9:0] q_alt[$];
  string      q_tag[$];

  function automatic logic [9:0] mk(input logic [1:0] fa, input logic [1:0] fb,
      input logic hp, input logic hf, input logic bd, input logic ff,
      input logic fx, input logic ie);
    return {fa, fb, hp, hf, bd, ff, fx, ie};
  endfunction

  localparam logic [9:0] ZERO = 10'd0;

  task automatic clr();
    dec_valid = 0; dec_is_branch = 0; src_a = 0; src_b = 0;
    dbuf_valid = 0; dbuf_wr = 0; dbuf_load = 0; dbuf_rd = 0;
    xbuf_valid = 0; xbuf_wr = 0; xbuf_rd = 0;
    mbuf_valid = 0; mbuf_wr = 0; mbuf_rd = 0;
    br_resolved = 0; br_taken = 0; irq_req = 0;
  endtask

  // driver: inputs already set; queue expectations, move to next cycle
  task automatic step(input logic [9:0] em, input logic [9:0] ea, input string tag);
    q_main.push_back(em);
    q_alt.push_back(ea);
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_tag.size() > 0) begin
        logic [9:0] em, ea, gm, ga;
        string t;
        em = q_main.pop_front();
        ea = q_alt.pop_front();
        t  = q_tag.pop_front();
        gm = {m_fa, m_fb, m_hp, m_hf, m_bd, m_ff, m_fx, m_ie};
        ga = {a_fa, a_fb, a_hp, a_hf, a_bd, a_ff, a_fx, a_ie};
        checks += 2;
        if (gm !== em) begin
          failures++;
          $display("FAIL %s (stall/drain variant) actual=%b expected=%b", t, gm, em);
        end
        if (ga !== ea) begin
          failures++;
          $display("FAIL %s (predict/flush variant) actual=%b expected=%b", t, ga, ea);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 reset state
    step(ZERO, ZERO, "R11 idle after reset");

    // R1 single forward from decode-output buffer
    clr(); src_a = 3; src_b = 9; dbuf_valid = 1; dbuf_wr = 1; dbuf_rd = 3;
    step(mk(1,0,0,0,0,0,0,0), mk(1,0,0,0,0,0,0,0), "R1 dbuf forward");

    // R1 execute and memory buffer codes
    clr(); src_a = 12; src_b = 9; xbuf_valid = 1; xbuf_wr = 1; xbuf_rd = 9;
    mbuf_valid = 1; mbuf_wr = 1; mbuf_rd = 12;
    step(mk(3,2,0,0,0,0,0,0), mk(3,2,0,0,0,0,0,0), "R1 xbuf/mbuf codes");

    // R2 priority youngest first
    clr(); src_a = 5; src_b = 5;
    dbuf_valid = 1; dbuf_wr = 1; dbuf_rd = 5;
    xbuf_valid = 1; xbuf_wr = 1; xbuf_rd = 5;
    mbuf_valid = 1; mbuf_wr = 1; mbuf_rd = 5;
    step(mk(1,1,0,0,0,0,0,0), mk(1,1,0,0,0,0,0,0), "R2 all match");
    dbuf_wr = 0;
    step(mk(2,2,0,0,0,0,0,0), mk(2,2,0,0,0,0,0,0), "R2 xbuf over mbuf");
    xbuf_valid = 0;
    step(mk(3,3,0,0,0,0,0,0), mk(3,3,0,0,0,0,0,0), "R2 mbuf only");

    // R3 register zero and no-write buffer
    clr(); src_a = 0; dbuf_valid = 1; dbuf_wr = 1; dbuf_rd = 0;
    src_b = 7; xbuf_valid = 1; xbuf_wr = 0; xbuf_rd = 7;
    step(ZERO, ZERO, "R3 r0 and no-write");

    // R4 load-use one-cycle stall
    clr(); dec_valid = 1; src_a = 1; src_b = 4;
    dbuf_valid = 1; dbuf_wr = 1; dbuf_load = 1; dbuf_rd = 4;
    step(mk(0,1,1,1,1,0,0,0), mk(0,1,1,1,1,0,0,0), "R4 load-use stall");
    clr(); dec_valid = 1; src_a = 1; src_b = 4;
    xbuf_valid = 1; xbuf_wr = 1; xbuf_rd = 4;
    step(mk(0,2,0,0,0,0,0,0), mk(0,2,0,0,0,0,0,0), "R4 after bubble");
    clr(); dec_valid = 1; src_a = 6; src_b = 7;
    dbuf_valid = 1; dbuf_wr = 1; dbuf_load = 1; dbuf_rd = 4;
    step(ZERO, ZERO, "R4 load no dependence");
    clr(); dec_valid = 0; src_b = 4;
    dbuf_valid = 1; dbuf_wr = 1; dbuf_load = 1; dbuf_rd = 4;
    step(mk(0,1,0,0,0,0,0,0), mk(0,1,0,0,0,0,0,0), "R4 decode invalid");
    clr(); dec_valid = 1; dec_is_branch = 1; src_a = 4;
    dbuf_valid = 1; dbuf_wr = 1; dbuf_load = 1; dbuf_rd = 4;
    step(mk(1,0,1,1,1,0,0,0), mk(1,0,1,1,1,0,0,0), "R4 over branch stall");

    // R6 / R7 branch in decode
    clr(); dec_valid = 1; dec_is_branch = 1;
    step(mk(0,0,1,0,0,1,0,0), ZERO, "R6 R7 branch in decode");

    // R5 taken resolution
    clr(); br_resolved = 1; br_taken = 1;
    step(mk(0,0,0,0,1,1,0,0), mk(0,0,0,0,1,1,0,0), "R5 taken flush");
    clr(); br_resolved = 1; br_taken = 1; dec_valid = 1; src_a = 4;
    dbuf_valid = 1; dbuf_wr = 1; dbuf_load = 1; dbuf_rd = 4;
    step(mk(1,0,0,0,1,1,0,0), mk(1,0,0,0,1,1,0,0), "R5 over load-use");

    // R7 not taken
    clr(); br_resolved = 1; br_taken = 0;
    step(ZERO, ZERO, "R7 not taken");

    // R8 drain / R10 flush
    clr(); irq_req = 1; dbuf_valid = 1; dbuf_wr = 1; dbuf_rd = 2;
    xbuf_valid = 1; mbuf_valid = 1;
    step(mk(0,0,1,1,1,0,0,0), mk(0,0,0,0,1,1,1,1), "R8 R10 request");
    clr(); xbuf_valid = 1; mbuf_valid = 1;
    step(mk(0,0,1,1,1,0,0,0), ZERO, "R8 draining x");
    clr(); mbuf_valid = 1;
    step(mk(0,0,1,1,1,0,0,0), ZERO, "R8 draining m");
    clr();
    step(mk(0,0,1,1,1,0,0,1), ZERO, "R8 enter");
    step(ZERO, ZERO, "R8 back to run");

    // R9 taken branch during drain
    clr(); irq_req = 1; xbuf_valid = 1;
    step(mk(0,0,1,1,1,0,0,0), mk(0,0,0,0,1,1,1,1), "R9 request");
    clr(); xbuf_valid = 1; br_resolved = 1; br_taken = 1;
    step(mk(0,0,0,0,1,1,0,0), mk(0,0,0,0,1,1,0,0), "R9 taken in drain");
    clr(); mbuf_valid = 1;
    step(mk(0,0,1,1,1,0,0,0), ZERO, "R9 drain continues");
    clr();
    step(mk(0,0,1,1,1,0,0,1), ZERO, "R9 enter");
    step(ZERO, ZERO, "R9 back to run");

    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule